// File: doc/BRIEF.md
# Two-Step Serial Code Lock

This block is a Moore state machine that decides whether a door may be released. The user sets a 2-bit switch word and presses a button. After a second word and a second press, the machine either grants access or flags a failure. The stored two-word code is fixed by parameters. Each word is compared as it arrives, and the machine remembers whether every word so far has matched.

A wrong first word is not reported at once. The machine still waits for the second press, so an observer cannot tell which word was wrong. Both final states hold until a synchronous reset. The raw button input passes through an edge detector, so a held press counts as one entry.

A parameter selects the state encoding. The binary variant keeps a 3-bit register with fixed codes. The one-hot variant keeps one flip-flop per state. Both variants behave the same at the ports.

Top module: `serial_code_lock`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine returns to its idle state whatever the other inputs are. After that edge, `unlock_o` and `alarm_o` are both 0.
- R2: The machine acts only on a 0-to-1 change of `press_i` between two clock edges. Holding `press_i` high for many cycles advances at most one state.
- R3: While no new press arrives, the state does not change, and neither do the outputs, in every non-final state.
- R4: A press with `code_sw_i == FIRST_WORD`, then a press with `code_sw_i == SECOND_WORD`, sets `unlock_o` to 1 on the clock edge that registers the second press. `alarm_o` stays 0.
- R5: If the first word is wrong, both outputs stay 0 after the first press. The next press sets `alarm_o` to 1 whatever the switch value is, even if it equals `SECOND_WORD`.
- R6: A correct first word followed by a press with any value other than `SECOND_WORD` sets `alarm_o` to 1 and keeps `unlock_o` at 0.
- R7: Once `unlock_o` or `alarm_o` is 1, it holds through any further presses and switch changes until reset.
- R8: The outputs depend on the present state only. `unlock_o` and `alarm_o` are never 1 together, and both are 0 in the idle state and after the first press.
- R9: With `ONE_HOT = 1`, the port behaviour is the same as with the binary encoding. Reset loads a single 1, in the idle flip-flop (bit 0). The binary codes are idle 000, first-ok 001, opened 011, first-bad 100 and failed 101.
- R10: `FIRST_WORD` and `SECOND_WORD` set the accepted code. The default code is 01 followed by 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| press_i | input | 1 | Raw entry button, level |
| code_sw_i | input | WORD_W (2) | Switch word presented with a press |
| unlock_o | output | 1 | High while the opened state is held |
| alarm_o | output | 1 | High while the failed state is held |

## Verification
The bench builds two copies of the lock side by side on the same stimulus. The first uses the binary encoding with the default 01/11 code. The second uses the one-hot encoding with the code 10/00. This puts the encoding variant and a non-default code within reach in one run. The second copy also shows that switch values correct for one lock count as wrong for the other. Directed sequences cover the correct code, a bad first word (including a correct second word afterward), a bad second word, held presses and reset part-way through a sequence. A long seeded random phase then compares both copies cycle by cycle against a bench reference model.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int STATE_W    = 3;
    localparam int NUM_STATES = 5;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 3'b000,
        ST_GOOD1 = 3'b001,
        ST_GOOD2 = 3'b011,
        ST_FAIL1 = 3'b100,
        ST_FAIL2 = 3'b101,
        ST_BOGUS = 3'b111
    } lock_state_e;

    typedef struct packed {
        logic unlock;
        logic alarm;
    } lock_out_t;

    // One-hot bit position of each legal state
    localparam int OH_IDLE  = 0;
    localparam int OH_GOOD1 = 1;
    localparam int OH_GOOD2 = 2;
    localparam int OH_FAIL1 = 3;
    localparam int OH_FAIL2 = 4;

    function automatic logic [NUM_STATES-1:0] to_onehot(input lock_state_e s);
        logic [NUM_STATES-1:0] v;
        v = '0;
        case (s)
            ST_GOOD1: v[OH_GOOD1] = 1'b1;
            ST_GOOD2: v[OH_GOOD2] = 1'b1;
            ST_FAIL1: v[OH_FAIL1] = 1'b1;
            ST_FAIL2: v[OH_FAIL2] = 1'b1;
            default:  v[OH_IDLE]  = 1'b1;
        endcase
        return v;
    endfunction

    function automatic lock_state_e from_onehot(input logic [NUM_STATES-1:0] v);
        lock_state_e s;
        case (v)
            5'b00001: s = ST_IDLE;
            5'b00010: s = ST_GOOD1;
            5'b00100: s = ST_GOOD2;
            5'b01000: s = ST_FAIL1;
            5'b10000: s = ST_FAIL2;
            default:  s = ST_BOGUS;
        endcase
        return s;
    endfunction

    function automatic lock_state_e from_binary(input logic [STATE_W-1:0] c);
        lock_state_e s;
        case (c)
            3'b000:  s = ST_IDLE;
            3'b001:  s = ST_GOOD1;
            3'b011:  s = ST_GOOD2;
            3'b100:  s = ST_FAIL1;
            3'b101:  s = ST_FAIL2;
            default: s = ST_BOGUS;
        endcase
        return s;
    endfunction

    function automatic lock_out_t decode_out(input lock_state_e s);
        lock_out_t o;
        o.unlock = (s == ST_GOOD2);
        o.alarm  = (s == ST_FAIL2);
        return o;
    endfunction

endpackage

// File: rtl/lock_press_detect.sv
module lock_press_detect (
    input  logic clk,
    input  logic rst,
    input  logic press_raw,
    output logic press_pulse
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= press_raw;
    end

    assign press_pulse = press_raw & ~prev_q;

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        press_pulse |=> !press_pulse) else $error("pulse longer than one cycle"); // R2

endmodule

// File: rtl/lock_next_state.sv
module lock_next_state #(
    parameter int WORD_W = 2,
    parameter logic [WORD_W-1:0] FIRST_WORD  = 2'b01,
    parameter logic [WORD_W-1:0] SECOND_WORD = 2'b11
) (
    input  lock_pkg::lock_state_e cur_state,
    input  logic                  press,
    input  logic [WORD_W-1:0]     sw,
    output lock_pkg::lock_state_e nxt_state
);
    import lock_pkg::*;

    logic hit_first, hit_second;
    assign hit_first  = (sw == FIRST_WORD);
    assign hit_second = (sw == SECOND_WORD);

    always_comb begin
        nxt_state = cur_state;
        case (cur_state)
            ST_IDLE:  if (press) nxt_state = hit_first  ? ST_GOOD1 : ST_FAIL1;
            ST_GOOD1: if (press) nxt_state = hit_second ? ST_GOOD2 : ST_FAIL2;
            ST_FAIL1: if (press) nxt_state = ST_FAIL2;
            ST_GOOD2: nxt_state = ST_GOOD2;
            ST_FAIL2: nxt_state = ST_FAIL2;
            default:  nxt_state = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/lock_state_store.sv
module lock_state_store #(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  lock_pkg::lock_state_e nxt_state,
    output lock_pkg::lock_state_e cur_state
);
    import lock_pkg::*;

    generate
        if (ONE_HOT) begin : g_onehot
            logic [NUM_STATES-1:0] oh_q;
            always_ff @(posedge clk) begin
                if (rst) oh_q <= NUM_STATES'(1) << OH_IDLE;
                else     oh_q <= to_onehot(nxt_state);
            end
            assign cur_state = from_onehot(oh_q);

            AST_ONEHOT_LEGAL: assert property (@(posedge clk) disable iff (rst)
                $onehot(oh_q)) else $error("one-hot register corrupt"); // R9
        end else begin : g_binary
            logic [STATE_W-1:0] bin_q;
            always_ff @(posedge clk) begin
                if (rst) bin_q <= ST_IDLE;
                else     bin_q <= nxt_state;
            end
            assign cur_state = from_binary(bin_q);

            AST_BINARY_LEGAL: assert property (@(posedge clk) disable iff (rst)
                cur_state != ST_BOGUS) else $error("binary state illegal"); // R9
        end
    endgenerate

endmodule

// File: rtl/serial_code_lock.sv
module serial_code_lock #(
    parameter int WORD_W = 2,
    parameter logic [WORD_W-1:0] FIRST_WORD  = 2'b01,
    parameter logic [WORD_W-1:0] SECOND_WORD = 2'b11,
    parameter bit ONE_HOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              press_i,
    input  logic [WORD_W-1:0] code_sw_i,
    output logic              unlock_o,
    output logic              alarm_o
);
    import lock_pkg::*;

    logic        press_pulse;
    lock_state_e cur_state, nxt_state;
    lock_out_t   outs;

    lock_press_detect u_press (
        .clk         (clk),
        .rst         (rst),
        .press_raw   (press_i),
        .press_pulse (press_pulse)
    );

    lock_next_state #(
        .WORD_W      (WORD_W),
        .FIRST_WORD  (FIRST_WORD),
        .SECOND_WORD (SECOND_WORD)
    ) u_next (
        .cur_state (cur_state),
        .press     (press_pulse),
        .sw        (code_sw_i),
        .nxt_state (nxt_state)
    );

    lock_state_store #(
        .ONE_HOT (ONE_HOT)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    assign outs     = decode_out(cur_state);
    assign unlock_o = outs.unlock;
    assign alarm_o  = outs.alarm;

    AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(unlock_o && alarm_o)) else $error("both outputs high"); // R8
    AST_UNLOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        unlock_o |=> unlock_o) else $error("unlock dropped"); // R7
    AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (rst)
        alarm_o |=> alarm_o) else $error("alarm dropped"); // R7
    AST_IDLE_NO_PRESS: assert property (@(posedge clk) disable iff (rst)
        (!press_pulse && cur_state != ST_BOGUS) |=> $stable(cur_state))
        else $error("state moved without press"); // R3

endmodule

// File: tb/serial_code_lock_tb.sv
module serial_code_lock_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst, press;
    logic [1:0] sw;
    logic       un_b, al_b, un_h, al_h;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // bench model: 0 idle, 1 good1, 2 good2, 3 fail1, 4 fail2
    int  m_b, m_h;
    bit  m_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_code_lock #(.FIRST_WORD(2'b01), .SECOND_WORD(2'b11), .ONE_HOT(1'b0)) dut_i (
        .clk(clk), .rst(rst), .press_i(press), .code_sw_i(sw),
        .unlock_o(un_b), .alarm_o(al_b));

    serial_code_lock #(.FIRST_WORD(2'b10), .SECOND_WORD(2'b00), .ONE_HOT(1'b1)) dut_oh_i (
        .clk(clk), .rst(rst), .press_i(press), .code_sw_i(sw),
        .unlock_o(un_h), .alarm_o(al_h));

    function automatic int model_next(int s, bit p, logic [1:0] w, logic [1:0] f1, logic [1:0] f2);
        if (!p) return s;
        case (s)
            0: return (w == f1) ? 1 : 3;
            1: return (w == f2) ? 2 : 4;
            3: return 4;
            default: return s;
        endcase
    endfunction

    task automatic chk(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d: actual %b expected %b", tag, what, cyc, act, exp);
        end
    endtask

    task automatic cycle(bit r, bit p, logic [1:0] w, string tag);
        bit pulse;
        @(negedge clk);
        rst = r; press = p; sw = w;
        @(posedge clk);
        cyc++;
        pulse = p && !m_prev;
        if (r) begin
            m_b = 0; m_h = 0; m_prev = 1'b0;
        end else begin
            m_b = model_next(m_b, pulse, w, 2'b01, 2'b11);
            m_h = model_next(m_h, pulse, w, 2'b10, 2'b00);
            m_prev = p;
        end
        #(CLK_PERIOD/4);
        chk(tag, un_b, m_b == 2, "bin unlock");
        chk(tag, al_b, m_b == 4, "bin alarm");
        chk(tag, un_h, m_h == 2, "oh unlock");
        chk(tag, al_h, m_h == 4, "oh alarm");
    endtask

    task automatic do_reset(string tag);
        cycle(1'b1, 1'b0, 2'b00, tag);
        cycle(1'b0, 1'b0, 2'b00, tag);
    endtask

    // one press: rise then release
    task automatic enter_word(logic [1:0] w, string tag);
        cycle(1'b0, 1'b1, w, tag);
        cycle(1'b0, 1'b0, w, tag);
    endtask

    initial begin
        rst = 1'b1; press = 1'b0; sw = 2'b00;
        m_b = 0; m_h = 0; m_prev = 1'b0;

        // R1: reset state, reset wins over a press
        cycle(1'b1, 1'b1, 2'b01, "R1");
        cycle(1'b1, 1'b0, 2'b01, "R1");
        cycle(1'b0, 1'b0, 2'b00, "R1");

        // R4 R10: correct code on binary lock (01,11); idle holds R3
        cycle(1'b0, 1'b0, 2'b01, "R3");
        enter_word(2'b01, "R8");
        enter_word(2'b11, "R4");
        // R7: further presses ignored
        enter_word(2'b00, "R7");
        enter_word(2'b10, "R7");
        do_reset("R1");

        // R10 R9: correct code on one-hot lock (10,00)
        enter_word(2'b10, "R9");
        enter_word(2'b00, "R10");
        enter_word(2'b11, "R7");
        do_reset("R1");

        // R5: wrong first word, then correct second word still fails
        enter_word(2'b00, "R5");
        repeat (3) cycle(1'b0, 1'b0, 2'b11, "R3");
        enter_word(2'b11, "R5");
        enter_word(2'b01, "R7");
        do_reset("R1");

        // R6: good first, wrong second
        enter_word(2'b01, "R6");
        enter_word(2'b10, "R6");
        do_reset("R1");

        // R2: held press advances one step only
        repeat (6) cycle(1'b0, 1'b1, 2'b01, "R2");
        repeat (4) cycle(1'b0, 1'b1, 2'b11, "R2");
        cycle(1'b0, 1'b0, 2'b11, "R2");
        enter_word(2'b11, "R4");

        // R1: reset part-way through a sequence
        do_reset("R1");
        enter_word(2'b01, "R1");
        cycle(1'b1, 1'b1, 2'b11, "R1");
        cycle(1'b0, 1'b0, 2'b11, "R1");
        enter_word(2'b01, "R1");
        enter_word(2'b11, "R4");
        do_reset("R1");

        // random phase, fixed seed
        begin
            int unsigned seed;
            seed = $urandom(32'd2024);
            for (int i = 0; i < 4000; i++) begin
                bit r, p;
                logic [1:0] w;
                r = ($urandom_range(0, 59) == 0);
                p = ($urandom_range(0, 2) == 0);
                w = 2'($urandom_range(0, 3));
                cycle(r, p, w, "R8");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule